// File: doc/BRIEF.md
# Thermal Threshold Interrupt Unit

This block watches an 8-bit temperature code delivered by a sensor front end with a valid strobe. It compares every accepted sample against three programmable rising thresholds. When a sample crosses a threshold upward, a sticky flag is set for that level. Each flag can be masked by an enable bit and cleared by writing 1 to it. The masked flags are ORed onto a single interrupt line.

Software reaches the block through a simple register port, with a write strobe and a combinational read. A control register starts and stops the core. A stopped core accepts no samples and keeps the interrupt line low.

For tests in the field, an emulation register can take the place of the live sensor code with a programmed code. The substitution starts only after a programmed delay counter has run down to zero. Writing the emulation register again restarts the delay.

Register offsets: control 0x00, rising thresholds 0x04, falling thresholds 0x08, interrupt enable 0x0C, status 0x10 (read), clear 0x14 (write), emulation 0x18, code in use 0x1C (read).

Top module: `thermal_irq_unit`

## Requirements
- R1: After reset, the control register reads 0x2 (stopped), status reads 0, the code-in-use register reads 0 and irq_o is low.
- R2: The rising-threshold register holds level 0 in bits 7:0, level 1 in bits 15:8 and level 2 in bits 23:16, and reads back as written. A sample meets a level when the code is at or above that level's threshold.
- R3: A level's flag sets on an accepted sample that meets the level when the previous accepted sample did not. The flag stays set until it is cleared. After a clear, the flag sets again only on a new upward crossing.
- R4: Status shows the level 0, 1 and 2 flags at bits 0, 4 and 8. Writing 1s at bits 0, 4 and 8 of the clear register clears the matching flags. Zero bits, and the falling clear bits 16, 20 and 24, leave the rising flags unchanged.
- R5: When a clear of a flag and a new set event for that flag happen in the same cycle, the flag ends set.
- R6: The enable register holds one bit per level, at bits 0, 4, 8 and 12. irq_o is the OR over levels of flag AND enable.
- R7: The core runs only when control bits 1:0 equal 3. While the core is stopped, no sample is accepted (flags and the code in use stay unchanged) and irq_o is low.
- R8: The emulation register has its enable at bit 0, the emulated code at bits 15:8 and the delay at bits 31:16. The emulated code replaces the live code only once the delay counter, which reloads on every write to this register, has reached zero.
- R9: When the emulation enable is written as 0, accepted samples use the live sensor code again.
- R10: The code-in-use register returns the code of the last accepted sample, whether measured or emulated, and that same code drives the threshold comparison.
- R11: The control register stores the gain in bits 11:8, the mode in bits 15:13, the mux address in bits 22:20 and the reference in bits 28:24, and reads them back. The falling-threshold register stores and reads back 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| code_i | input | 8 | Live temperature code |
| code_vld_i | input | 1 | Sample strobe for code_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The main comparison is driven with codes just below, exactly at and above each threshold. This separates an at-or-above test from a strictly-above test. Samples that stay above a level after a clear, followed by a drop below the level and a new rise, separate edge-set flags from level-set flags. A clear that arrives in the same cycle as a crossing, and clears of only the falling bits, show the clear priority and the clear bit positions. Emulation is tried with a sample before the delay expires, with a rewrite that restarts the delay, with a sample after expiry and with the enable removed. Together these show when the override is applied and that it is released.

// File: rtl/tti_pkg.sv
package tti_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] A_RISE = 6'h04;
  localparam logic [ADDR_W-1:0] A_FALL = 6'h08;
  localparam logic [ADDR_W-1:0] A_IEN  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_STAT = 6'h10;
  localparam logic [ADDR_W-1:0] A_CLR  = 6'h14;
  localparam logic [ADDR_W-1:0] A_EMU  = 6'h18;
  localparam logic [ADDR_W-1:0] A_CUR  = 6'h1C;

  // run field 1:0, gain 11:8, mode 15:13, mux 22:20, reference 28:24
  localparam logic [DATA_W-1:0] CTRL_MASK  = 32'h1F70_EF03;
  localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0000_0002;
  localparam logic [1:0]        RUN_CODE   = 2'b11;

  localparam int LVL_STRIDE = 4;
  localparam int FALL_BASE  = 16;
  localparam int EMU_CODE_LSB = 8;
  localparam int EMU_DLY_LSB  = 16;
endpackage

// File: rtl/tti_level.sv
module tti_level #(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] thr_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic              set_o
);
  logic above_q, meet;

  assign meet  = code_i >= thr_i;
  assign set_o = smp_vld_i & meet & ~above_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      above_q <= 1'b0;
      flag_o  <= 1'b0;
    end else begin
      if (smp_vld_i) above_q <= meet;
      // set dominates a concurrent clear
      flag_o <= set_o | (flag_o & ~clr_i);
    end
  end
endmodule

// File: rtl/tti_emu.sv
module tti_emu #(
  parameter int CODE_W = 8,
  parameter int DLY_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] emu_code_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic [CODE_W-1:0] live_code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              active_o
);
  logic [DLY_W-1:0]  cnt_q;
  logic              en_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      en_q   <= 1'b0;
      code_q <= '0;
    end else if (wr_i) begin
      cnt_q  <= dly_i;
      en_q   <= en_i;
      code_q <= emu_code_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = en_q & (cnt_q == '0);
  assign code_o   = active_o ? code_q : live_code_i;
endmodule

// File: rtl/thermal_irq_unit.sv
module thermal_irq_unit
  import tti_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int NUM_LVL = 3,
  parameter int NUM_EN  = 4,
  parameter int DLY_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [CODE_W-1:0] code_i,
  input  logic              code_vld_i,
  output logic              irq_o
);
  localparam int THR_W = NUM_LVL * CODE_W;

  logic [DATA_W-1:0] ctrl_q;
  logic [THR_W-1:0]  rise_thr_q, fall_thr_q;
  logic [NUM_EN-1:0] en_q;
  logic [CODE_W-1:0] cur_code_q, eff_code;
  logic [DATA_W-1:0] emu_q;
  logic [NUM_LVL-1:0] flag, set_evt, clr_vec;
  logic run, smp, emu_wr, clr_wr, emu_act;

  assign run    = ctrl_q[1:0] == RUN_CODE;
  assign smp    = code_vld_i & run;
  assign emu_wr = reg_we_i & (reg_addr_i == A_EMU);
  assign clr_wr = reg_we_i & (reg_addr_i == A_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= CTRL_RESET;
      rise_thr_q <= '0;
      fall_thr_q <= '0;
      en_q       <= '0;
      emu_q      <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_CTRL: ctrl_q     <= reg_wdata_i & CTRL_MASK;
        A_RISE: rise_thr_q <= reg_wdata_i[THR_W-1:0];
        A_FALL: fall_thr_q <= reg_wdata_i[THR_W-1:0];
        A_IEN:  for (int i = 0; i < NUM_EN; i++) en_q[i] <= reg_wdata_i[i*LVL_STRIDE];
        A_EMU:  emu_q      <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cur_code_q <= '0;
    else if (smp) cur_code_q <= eff_code;
  end

  tti_emu #(.CODE_W(CODE_W), .DLY_W(DLY_W)) u_emu (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (emu_wr),
    .en_i        (reg_wdata_i[0]),
    .emu_code_i  (reg_wdata_i[EMU_CODE_LSB +: CODE_W]),
    .dly_i       (reg_wdata_i[EMU_DLY_LSB +: DLY_W]),
    .live_code_i (code_i),
    .code_o      (eff_code),
    .active_o    (emu_act)
  );

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign clr_vec[g] = clr_wr & reg_wdata_i[g*LVL_STRIDE];
    tti_level #(.CODE_W(CODE_W)) u_lvl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .smp_vld_i (smp),
      .code_i    (eff_code),
      .thr_i     (rise_thr_q[g*CODE_W +: CODE_W]),
      .clr_i     (clr_vec[g]),
      .flag_o    (flag[g]),
      .set_o     (set_evt[g])
    );
  end

  assign irq_o = run & |(flag & en_q[NUM_LVL-1:0]);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: reg_rdata_o = ctrl_q;
      A_RISE: reg_rdata_o[THR_W-1:0] = rise_thr_q;
      A_FALL: reg_rdata_o[THR_W-1:0] = fall_thr_q;
      A_IEN:  for (int i = 0; i < NUM_EN; i++) reg_rdata_o[i*LVL_STRIDE] = en_q[i];
      A_STAT: for (int i = 0; i < NUM_LVL; i++) reg_rdata_o[i*LVL_STRIDE] = flag[i];
      A_EMU:  reg_rdata_o = emu_q;
      A_CUR:  reg_rdata_o[CODE_W-1:0] = cur_code_q;
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tti_checker.sv
module tti_checker #(
  parameter int NUM_LVL = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               irq_o,
  input logic               run,
  input logic [NUM_LVL-1:0] flag,
  input logic [NUM_LVL-1:0] en_lvl,
  input logic [NUM_LVL-1:0] set_evt,
  input logic [NUM_LVL-1:0] clr_vec,
  input logic               emu_wr,
  input logic [31:0]        wdata,
  input logic               emu_act
);
  a_r7_irq_low_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !irq_o);

  a_r6_irq_has_enabled_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(flag & en_lvl)));

  a_r5_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_evt) |=> ((flag & $past(set_evt)) == $past(set_evt)));

  a_r3_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flag & ~clr_vec)) |=> ((flag & $past(flag & ~clr_vec)) == $past(flag & ~clr_vec)));

  a_r8_delay_blocks_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emu_wr && wdata[0] && (wdata[31:16] != 16'd0)) |=> !emu_act);
endmodule

bind thermal_irq_unit tti_checker #(.NUM_LVL(NUM_LVL)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .run     (run),
  .flag    (flag),
  .en_lvl  (en_q[NUM_LVL-1:0]),
  .set_evt (set_evt),
  .clr_vec (clr_vec),
  .emu_wr  (emu_wr),
  .wdata   (reg_wdata_i),
  .emu_act (emu_act)
);

// File: tb/thermal_irq_unit_tb.sv
module thermal_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  code = '0;
  logic        vld = 1'b0;
  logic        irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [5:0] CTRL = 6'h00, RISE = 6'h04, FALL = 6'h08, IEN = 6'h0C,
                         STAT = 6'h10, CLR = 6'h14, EMU = 6'h18, CUR = 6'h1C;
  localparam logic [31:0] CTRL_RUN  = 32'h1060_8803;
  localparam logic [31:0] CTRL_STOP = 32'h1060_8802;

  always #2.5 clk = ~clk;

  thermal_irq_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .code_i(code),
    .code_vld_i(vld), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic smp(logic [7:0] c);
    @(negedge clk); code = c; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(CTRL, d); chk("R1 ctrl", d, 32'h2);
    rd(STAT, d); chk("R1 stat", d, 32'h0);
    rd(CUR, d);  chk("R1 cur", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(RISE, 32'h006E_6755);
    rd(RISE, d); chk("R2 rise readback", d, 32'h006E_6755);
    wr(FALL, 32'h00A5_5A3C);
    rd(FALL, d); chk("R11 fall readback", d, 32'h00A5_5A3C);
    wr(CTRL, CTRL_RUN | 32'h8000_0004);
    rd(CTRL, d); chk("R11 ctrl fields", d, CTRL_RUN);
    wr(IEN, 32'h0000_1111);
    rd(IEN, d); chk("R6 enable readback", d, 32'h0000_1111);
  endtask

  task automatic t_cross();
    logic [31:0] d;
    smp(8'd84); rd(STAT, d); chk("R2 below thr", d, 32'h0);
    chk("R6 irq idle", {31'b0, irq}, 32'h0);
    smp(8'd85); rd(STAT, d); chk("R2 equal thr", d, 32'h001);
    chk("R6 irq raised", {31'b0, irq}, 32'h1);
    smp(8'd104); rd(STAT, d); chk("R3 level1", d, 32'h011);
    smp(8'd110); rd(STAT, d); chk("R3 level2", d, 32'h111);
    rd(CUR, d); chk("R10 live code", d, 32'd110);
    wr(CLR, 32'h0000_0010); rd(STAT, d); chk("R4 clear bit4", d, 32'h101);
    smp(8'd105); rd(STAT, d); chk("R3 no reset while above", d, 32'h101);
    smp(8'd90); smp(8'd103); rd(STAT, d); chk("R3 recross", d, 32'h111);
    wr(CLR, 32'h0111_0000); rd(STAT, d); chk("R4 fall bits ignored", d, 32'h111);
    wr(CLR, 32'h0000_0000); rd(STAT, d); chk("R4 zero bits ignored", d, 32'h111);
    wr(CLR, 32'h0000_0111); rd(STAT, d); chk("R4 clear all", d, 32'h0);
    chk("R6 irq cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    smp(8'd50);
    wr(IEN, 32'h0);
    smp(8'd90); rd(STAT, d); chk("R6 flag while masked", d, 32'h001);
    chk("R6 masked irq", {31'b0, irq}, 32'h0);
    wr(IEN, 32'h1); chk("R6 unmasked irq", {31'b0, irq}, 32'h1);
    wr(CLR, 32'h111); wr(IEN, 32'h1111);
  endtask

  task automatic t_simul();
    logic [31:0] d;
    smp(8'd50);
    @(negedge clk); code = 8'd90; vld = 1'b1; we = 1'b1; addr = CLR; wdata = 32'h1;
    @(negedge clk); vld = 1'b0; we = 1'b0;
    rd(STAT, d); chk("R5 set wins", d, 32'h001);
    wr(CLR, 32'h111);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    smp(8'd50); smp(8'd90);
    chk("R7 irq running", {31'b0, irq}, 32'h1);
    wr(CTRL, CTRL_STOP);
    chk("R7 irq stopped", {31'b0, irq}, 32'h0);
    wr(CLR, 32'h111);
    smp(8'd50); smp(8'd120);
    rd(STAT, d); chk("R7 no flags stopped", d, 32'h0);
    rd(CUR, d); chk("R7 cur frozen", d, 32'd90);
    wr(CTRL, CTRL_RUN);
  endtask

  task automatic t_emu();
    logic [31:0] d;
    smp(8'd40);
    wr(EMU, 32'h0014_7A01);
    smp(8'd45); rd(CUR, d); chk("R8 before delay", d, 32'd45);
    idle(8);
    wr(EMU, 32'h0014_7A01);
    idle(12);
    smp(8'd46); rd(CUR, d); chk("R8 reload delay", d, 32'd46);
    rd(STAT, d); chk("R8 no flags yet", d, 32'h0);
    idle(12);
    smp(8'd47); rd(CUR, d); chk("R10 emulated code", d, 32'h7A);
    rd(STAT, d); chk("R10 emulated compare", d, 32'h111);
    rd(EMU, d); chk("R8 emu readback", d, 32'h0014_7A01);
    wr(EMU, 32'h0);
    smp(8'd60); rd(CUR, d); chk("R9 live again", d, 32'd60);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_regs();
    t_cross();
    t_enable();
    t_simul();
    t_stop();
    t_emu();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog got=timeout exp=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule